// File: doc/BRIEF.md
# Colour Look-Up Table with Auto-Stepping Host Port

This block holds a 256-entry colour table. Every entry carries an 8-bit red, an 8-bit green and an 8-bit blue value. Software programs and inspects the table through three word-wide registers: a write pointer, a read pointer and a data window. A single two-bit phase counter is shared by both pointers. It decides which colour channel the next data access touches. After the blue channel it moves the relevant pointer on to the next entry, so software can stream whole palettes with no pointer rewrites.

A second, independent port serves the display pipeline. Each cycle it takes an 8-bit pixel code and returns the 24-bit colour stored for it one cycle later. This port has no path into the pointers or the phase counter.

The register port takes at most one access per cycle. When a write and a read are presented together, the write is performed and the read is dropped. Read data is registered and appears one cycle after the read strobe.

Top module: `clut_port`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, both pointers, the phase counter, `reg_rdata` and `pix_rgb` are all zero.
- R2: A write to address 0 loads the write pointer from `reg_wdata[7:0]`. A write to address 2 loads the read pointer the same way. Either write clears the phase counter.
- R3: A write to address 1 stores `reg_wdata[7:0]` (upper bits ignored) into the channel chosen by the phase counter, in the entry chosen by the write pointer. Phase 0 is red, phase 1 is green and phase 2 is blue. The phase then advances by one.
- R4: A data write at phase 2 returns the phase to 0 and adds one to the write pointer, wrapping from 255 to 0.
- R5: A read of address 1 returns, on `reg_rdata[7:0]` in the next cycle, the channel chosen by the phase counter of the entry chosen by the read pointer. It then advances the phase. At phase 2 it clears the phase and adds one to the read pointer, wrapping from 255 to 0.
- R6: Data writes and data reads step the same phase counter, so interleaved accesses continue from each other's phase. The counter never holds the value 3.
- R7: A read of address 0 or address 2 returns the write or read pointer, zero-extended, one cycle later. A read of address 3 returns zero. None of these reads changes any state, and `reg_rdata` holds its value between reads.
- R8: `pix_rgb` equals {red, green, blue} (red in bits 23:16, blue in bits 7:0) of the entry addressed by `pix_idx` at the previous clock edge. The pixel port never changes the pointers or the phase counter.
- R9: When a data write and a pixel lookup address the same entry in the same cycle, the pixel port returns the colour as it was before the write.
- R10: When `reg_wr` and `reg_rd` are both high, only the write takes effect. `reg_rdata` is unchanged and the phase advances once at most.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 write pointer, 1 data, 2 read pointer, 3 unused |
| reg_wdata | input | DATA_W | Write data; only the low 8 bits are used |
| reg_rdata | output | DATA_W | Registered read data |
| pix_idx | input | IDX_W | Pixel colour code to look up |
| pix_rgb | output | 3*COMP_W | Colour for the code of the previous cycle |

## Verification
The bench writes values whose upper bits are set, to catch a design that stores more than the low byte. It interleaves writes and reads so the phase counter is shared between them; a design with two private counters would return the wrong channel there. It drives both pointers across the 255-to-0 boundary, where a wide or saturating increment would show up as a wrong pointer read-back. It also issues a pixel lookup in the same cycle as a data write to that entry, which exposes a write-through path, and a write with a read in the same cycle, which shows whether the dropped read still stepped the counter or changed `reg_rdata`.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Register select decoding on the host port.
    typedef enum logic [1:0] {
        SEL_WPTR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_RPTR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Channel phase: red first, then green, then blue.
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    localparam int NUM_CH = 3;

    // Step to the next channel, wrapping after blue.
    function automatic phase_e phase_step(input phase_e ph);
        return (ph == PH_BLUE) ? PH_RED : phase_e'(ph + 2'd1);
    endfunction

    // True when this access completes an entry.
    function automatic logic phase_wraps(input phase_e ph);
        return ph == PH_BLUE;
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  wptr,
    output logic [IDX_W-1:0]  rptr,
    output phase_e            phase,
    output logic [NUM_CH-1:0] ch_we,
    output logic              data_rd
);

    logic do_wr;
    logic do_rd;

    // A write wins over a read presented in the same cycle (R10).
    assign do_wr   = wr;
    assign do_rd   = rd & ~wr;
    assign data_rd = do_rd && (sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            phase <= PH_RED;
        end else if (do_wr) begin
            unique case (sel)
                SEL_WPTR: begin
                    wptr  <= wdata[IDX_W-1:0];
                    phase <= PH_RED;
                end
                SEL_RPTR: begin
                    rptr  <= wdata[IDX_W-1:0];
                    phase <= PH_RED;
                end
                SEL_DATA: begin
                    phase <= phase_step(phase);
                    if (phase_wraps(phase))
                        wptr <= wptr + IDX_W'(1);
                end
                default: ;
            endcase
        end else if (data_rd) begin
            phase <= phase_step(phase);
            if (phase_wraps(phase))
                rptr <= rptr + IDX_W'(1);
        end
    end

    // One write enable per channel bank, selected by the phase.
    always_comb begin
        for (int k = 0; k < NUM_CH; k++)
            ch_we[k] = do_wr && (sel == SEL_DATA) && (phase == phase_e'(k));
    end

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COMP_W-1:0] wdata,
    input  logic [IDX_W-1:0]  bus_raddr,
    output logic [COMP_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  pix_raddr,
    output logic [COMP_W-1:0] pix_rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [COMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Host side is sampled into the read register by the top.
    assign bus_rdata = mem[bus_raddr];

    // Display side: registered, sees the pre-write contents (R9).
    always_ff @(posedge clk) begin
        if (rst)
            pix_rdata <= '0;
        else
            pix_rdata <= mem[pix_raddr];
    end

endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [1:0]               reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic [NUM_CH*COMP_W-1:0] pix_rgb
);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  seq_wptr;
    logic [IDX_W-1:0]  seq_rptr;
    phase_e            seq_phase;
    logic [NUM_CH-1:0] ch_we;
    logic              data_rd;
    logic [COMP_W-1:0] bus_ch [NUM_CH];
    logic [COMP_W-1:0] pix_ch [NUM_CH];

    assign sel = reg_sel_e'(reg_addr);

    clut_seq #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .sel     (sel),
        .wdata   (reg_wdata),
        .wptr    (seq_wptr),
        .rptr    (seq_rptr),
        .phase   (seq_phase),
        .ch_we   (ch_we),
        .data_rd (data_rd)
    );

    // One storage bank per colour channel.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        clut_bank #(
            .IDX_W  (IDX_W),
            .COMP_W (COMP_W)
        ) bank_i (
            .clk       (clk),
            .rst       (rst),
            .we        (ch_we[k]),
            .waddr     (seq_wptr),
            .wdata     (reg_wdata[COMP_W-1:0]),
            .bus_raddr (seq_rptr),
            .bus_rdata (bus_ch[k]),
            .pix_raddr (pix_idx),
            .pix_rdata (pix_ch[k])
        );
        // Red occupies the most significant byte.
        assign pix_rgb[(NUM_CH-k)*COMP_W-1 -: COMP_W] = pix_ch[k];
    end

    // Registered host read data; only updated by an accepted read (R7).
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd && !reg_wr) begin
            unique case (sel)
                SEL_WPTR: reg_rdata <= DATA_W'(seq_wptr);
                SEL_RPTR: reg_rdata <= DATA_W'(seq_rptr);
                SEL_DATA: reg_rdata <= DATA_W'(bus_ch[seq_phase]);
                default:  reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [IDX_W-1:0] wptr,
    input logic [IDX_W-1:0] rptr,
    input logic [1:0]       phase
);

    assert_ptr_load_clears_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == 2'd0 || reg_addr == 2'd2)) |=> (phase == 2'd0));

    assert_data_write_mid_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && phase != 2'd2)
        |=> (phase == $past(phase) + 2'd1) && $stable(wptr));

    assert_write_entry_step_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && phase == 2'd2)
        |=> (wptr == $past(wptr) + IDX_W'(1)) && (phase == 2'd0));

    assert_read_entry_step_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 2'd1 && phase == 2'd2)
        |=> (rptr == $past(rptr) + IDX_W'(1)) && (phase == 2'd0));

    assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3);

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && !reg_rd) |=> $stable(wptr) && $stable(rptr) && $stable(phase));

    assert_dual_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_rd && reg_addr == 2'd1)
        |=> $stable(rptr));

endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .wptr     (seq_wptr),
    .rptr     (seq_rptr),
    .phase    (seq_phase)
);

// File: tb/clut_port_tb_top.sv
`timescale 1ns/1ps
module clut_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clut_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pix_idx   (pix_idx),
        .pix_rgb   (pix_rgb)
    );

    // op 0: register write, 1: register read and compare, 2: pixel compare
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 32'h05,       32'h0},      // wptr=5 (R2)
        '{2'd0, 2'd1, 32'h11,       32'h0},      // red (R3)
        '{2'd0, 2'd1, 32'h22,       32'h0},      // green
        '{2'd0, 2'd1, 32'h33,       32'h0},      // blue, wptr->6 (R4)
        '{2'd1, 2'd0, 32'h0,        32'h06},     // wptr read-back (R7)
        '{2'd0, 2'd1, 32'hFFFFFFA4, 32'h0},      // upper bits dropped (R3)
        '{2'd0, 2'd1, 32'h5B,       32'h0},
        '{2'd0, 2'd1, 32'hC6,       32'h0},      // wptr->7
        '{2'd2, 2'd0, 32'h05,       32'h112233}, // pixel (R8)
        '{2'd2, 2'd0, 32'h06,       32'hA45BC6},
        '{2'd0, 2'd2, 32'h05,       32'h0},      // rptr=5
        '{2'd1, 2'd1, 32'h0,        32'h11},     // data reads (R5)
        '{2'd1, 2'd1, 32'h0,        32'h22},
        '{2'd1, 2'd1, 32'h0,        32'h33},     // rptr->6
        '{2'd1, 2'd2, 32'h0,        32'h06},
        '{2'd1, 2'd1, 32'h0,        32'hA4},     // phase now 1
        '{2'd0, 2'd0, 32'h05,       32'h0},      // clears phase (R2)
        '{2'd0, 2'd1, 32'h77,       32'h0},      // red of entry 5
        '{2'd2, 2'd0, 32'h05,       32'h772233},
        '{2'd2, 2'd0, 32'h05,       32'h772233}, // lookups leave phase (R8)
        '{2'd0, 2'd1, 32'h88,       32'h0},      // green of entry 5
        '{2'd2, 2'd0, 32'h05,       32'h778833},
        '{2'd0, 2'd2, 32'h06,       32'h0},      // rptr load clears phase
        '{2'd1, 2'd1, 32'h0,        32'hA4},
        '{2'd0, 2'd0, 32'h09,       32'h0},
        '{2'd0, 2'd2, 32'h05,       32'h0},
        '{2'd0, 2'd1, 32'h40,       32'h0},      // write red, phase 1 (R6)
        '{2'd1, 2'd1, 32'h0,        32'h88},     // read continues: green
        '{2'd0, 2'd1, 32'h50,       32'h0},      // write blue, wptr->10
        '{2'd1, 2'd0, 32'h0,        32'h0A},
        '{2'd1, 2'd2, 32'h0,        32'h05},
        '{2'd1, 2'd1, 32'h0,        32'h77}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pix_look(input logic [7:0] i, output logic [23:0] c);
        @(negedge clk);
        pix_idx = i;
        @(negedge clk);
        c = pix_rgb;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rv;
        logic [23:0] cv;
        logic [31:0] prev;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
        check(pix_rgb == 24'h0, "R1 pix", {8'h0, pix_rgb}, 32'h0);
        bus_rd(2'd0, rv); check(rv == 32'h0, "R1 wptr", rv, 32'h0);
        bus_rd(2'd2, rv); check(rv == 32'h0, "R1 rptr", rv, 32'h0);

        // Table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                2'd0: bus_wr(VECS[v].addr, VECS[v].data);
                2'd1: begin
                    bus_rd(VECS[v].addr, rv);
                    check(rv == VECS[v].exp, $sformatf("R3-R8 table vector %0d", v), rv, VECS[v].exp);
                end
                default: begin
                    pix_look(VECS[v].data[7:0], cv);
                    check({8'h0, cv} == VECS[v].exp, $sformatf("R8 table vector %0d", v), {8'h0, cv}, VECS[v].exp);
                end
            endcase
        end

        // R4: write pointer wraps 255 -> 0
        bus_wr(2'd0, 32'hFF);
        bus_wr(2'd1, 32'h01); bus_wr(2'd1, 32'h02); bus_wr(2'd1, 32'h03);
        bus_rd(2'd0, rv); check(rv == 32'h0, "R4 wrap", rv, 32'h0);
        pix_look(8'hFF, cv); check(cv == 24'h010203, "R4 entry 255", {8'h0, cv}, 32'h010203);

        // R5: read pointer wraps 255 -> 0
        bus_wr(2'd2, 32'hFF);
        bus_rd(2'd1, rv); check(rv == 32'h01, "R5 red", rv, 32'h01);
        bus_rd(2'd1, rv); check(rv == 32'h02, "R5 green", rv, 32'h02);
        bus_rd(2'd1, rv); check(rv == 32'h03, "R5 blue", rv, 32'h03);
        bus_rd(2'd2, rv); check(rv == 32'h0, "R5 wrap", rv, 32'h0);

        // R9: same-cycle write and lookup of entry 5
        bus_wr(2'd0, 32'h05);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h99; pix_idx = 8'h05;
        @(negedge clk);
        reg_wr = 1'b0;
        check(pix_rgb == 24'h778833, "R9 old colour", {8'h0, pix_rgb}, 32'h778833);
        @(negedge clk);
        check(pix_rgb == 24'h998833, "R9 new colour", {8'h0, pix_rgb}, 32'h998833);

        // R10: write and read together
        bus_wr(2'd0, 32'h05);
        prev = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h12;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check(reg_rdata == prev, "R10 rdata held", reg_rdata, prev);
        bus_wr(2'd1, 32'h34);
        pix_look(8'h05, cv); check(cv == 24'h123433, "R10 single step", {8'h0, cv}, 32'h123433);

        // R7: unused address reads zero; pointer unchanged by it
        bus_rd(2'd3, rv); check(rv == 32'h0, "R7 unused addr", rv, 32'h0);
        bus_rd(2'd0, rv); check(rv == 32'h05, "R7 wptr kept", rv, 32'h05);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule